// File: doc/BRIEF.md
# Dual-Granularity Sparing Redirector

This block sits in the address path of a stacked memory controller and steers accesses away from regions already known to be faulty. It keeps two redirection tables. The fine table maps single faulty rows, by die, bank and row, onto consecutive rows of one fine spare bank. The coarse table maps a whole faulty bank, by die and bank, onto one of two coarse spare banks. Every lookup checks both tables. The translated address comes out one cycle later on a valid/ready stream.

Entries are added through a plain management port once error correction has repaired the data of a region. Faults tend to hit either a few rows or thousands of rows. An install for a bank that already holds the promotion threshold of row entries therefore retires those row entries and replaces the whole bank with a free coarse spare. If neither a spare row nor a promotion is available, the install is refused and a sticky exhaustion flag is raised. All existing mappings stay as they were.

Lookup streams follow these rules. A lookup is accepted when `lk_valid` and `lk_ready` are both high at a clock edge. `lk_ready` is high whenever the output register is empty or `rs_ready` is high. A presented result holds all of its fields until `rs_ready` takes it.

Top module: `spr_redirector`

## Requirements
- R1: After reset, `rs_valid`, `mg_ack` and `exhausted` are 0, `lk_ready` is 1, and every lookup is treated as unmapped.
- R2: An accepted lookup gives its result with `rs_valid` high one cycle later. `lk_ready` equals `!rs_valid || rs_ready`. While `rs_valid && !rs_ready`, every result field stays stable.
- R3: A lookup that hits neither table returns region code 0 (original) with die, bank and row unchanged.
- R4: A lookup that hits only the fine table returns region code 1 (fine spare), die 0, bank equal to the number of coarse spare banks (2), and the allocated spare row in the row field.
- R5: Spare rows of the fine bank are allocated in increasing order from 0. A row freed by a promotion is never handed out again.
- R6: A lookup for a bank in the coarse table returns region code 2 (coarse spare), die 0, the coarse spare index as bank, and the original row. The coarse table wins over any fine entry.
- R7: Each management request gets `mg_ack` one cycle later, with `mg_result` set to 0 (row installed), 1 (bank promoted), 2 (already covered) or 3 (refused).
- R8: An install for a row already mapped, or for a bank already spared, returns 2 and changes no mapping.
- R9: An install for a bank that already holds 4 fine entries, while a coarse spare is free, takes the lowest free coarse index and invalidates that bank's fine entries.
- R10: When both coarse spares are in use, an install at the threshold falls back to row sparing.
- R11: When no spare row is left and no promotion applies, the install returns 3 and `exhausted` goes high. The flag stays high until reset, and the existing mappings are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_die | input | DIE_W | Lookup die |
| lk_bank | input | BANK_W | Lookup bank |
| lk_row | input | ROW_W | Lookup row |
| rs_valid | output | 1 | Translated result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_region | output | 2 | 0 original, 1 fine spare, 2 coarse spare |
| rs_die | output | DIE_W | Translated die (0 for spare regions) |
| rs_bank | output | BANK_W | Translated bank or spare bank index |
| rs_row | output | ROW_W | Translated row |
| mg_req | input | 1 | Install request, one cycle |
| mg_die | input | DIE_W | Die of the corrected row |
| mg_bank | input | BANK_W | Bank of the corrected row |
| mg_row | input | ROW_W | Corrected row |
| mg_ack | output | 1 | Install handled, one cycle after `mg_req` |
| mg_result | output | 2 | Install outcome code |
| exhausted | output | 1 | Sticky: an install was refused |

## Verification
A lookup accepted at one rising edge shows its result at the next edge. The bench presents each request at a falling edge and reads the result at the following falling edge, half a cycle after the result register loads. A management request is handled at the edge that samples it: `mg_ack`, `mg_result` and the table update all appear one cycle later. The bench therefore reads the outcome at the next falling edge and presents later lookups only after that edge. For back-pressure, the bench stalls the output, swaps the pending request, and confirms across two edges that the held result does not move.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    REG_ORIG   = 2'd0,
    REG_FINE   = 2'd1,
    REG_COARSE = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    INS_ROW     = 2'd0,
    INS_PROMOTE = 2'd1,
    INS_COVERED = 2'd2,
    INS_REFUSED = 2'd3
  } ins_res_e;
endpackage

// File: rtl/spr_row_table.sv
module spr_row_table #(
  parameter int DIE_W   = 3,
  parameter int BANK_W  = 3,
  parameter int ROW_W   = 16,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIE_W-1:0]  q_die,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              q_hit,
  output logic [IDX_W-1:0]  q_spare,
  input  logic [DIE_W-1:0]  m_die,
  input  logic [BANK_W-1:0] m_bank,
  input  logic [ROW_W-1:0]  m_row,
  output logic              m_row_hit,
  output logic [CNT_W-1:0]  m_bank_cnt,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              inv_en
);
  logic [ENTRIES-1:0] vld_q;
  logic [DIE_W-1:0]   die_q   [ENTRIES];
  logic [BANK_W-1:0]  bank_q  [ENTRIES];
  logic [ROW_W-1:0]   row_q   [ENTRIES];
  logic [IDX_W-1:0]   spare_q [ENTRIES];
  logic [IDX_W-1:0]   q_idx;

  always_comb begin
    q_hit      = 1'b0;
    q_idx      = '0;
    m_row_hit  = 1'b0;
    m_bank_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && die_q[i] == q_die && bank_q[i] == q_bank && row_q[i] == q_row) begin
        q_hit = 1'b1;
        q_idx = IDX_W'(i);
      end
      if (vld_q[i] && die_q[i] == m_die && bank_q[i] == m_bank) begin
        m_bank_cnt = m_bank_cnt + CNT_W'(1);
        if (row_q[i] == m_row) m_row_hit = 1'b1;
      end
    end
  end

  assign q_spare = spare_q[q_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_en && die_q[i] == m_die && bank_q[i] == m_bank) vld_q[i] <= 1'b0;
      end
      if (wr_en) vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      die_q[wr_idx]   <= m_die;
      bank_q[wr_idx]  <= m_bank;
      row_q[wr_idx]   <= m_row;
      spare_q[wr_idx] <= wr_idx;
    end
  end
endmodule

// File: rtl/spr_bank_table.sv
module spr_bank_table #(
  parameter int DIE_W  = 3,
  parameter int BANK_W = 3,
  parameter int SLOTS  = 2,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIE_W-1:0]  q_die,
  input  logic [BANK_W-1:0] q_bank,
  output logic              q_hit,
  output logic [SLOT_W-1:0] q_idx,
  input  logic [DIE_W-1:0]  m_die,
  input  logic [BANK_W-1:0] m_bank,
  output logic              m_hit,
  output logic              free_any,
  input  logic              wr_en
);
  logic [SLOTS-1:0]  vld_q;
  logic [DIE_W-1:0]  die_q  [SLOTS];
  logic [BANK_W-1:0] bank_q [SLOTS];
  logic [SLOT_W-1:0] free_idx;

  always_comb begin
    q_hit    = 1'b0;
    q_idx    = '0;
    m_hit    = 1'b0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vld_q[i] && die_q[i] == q_die && bank_q[i] == q_bank) begin
        q_hit = 1'b1;
        q_idx = SLOT_W'(i);
      end
      if (vld_q[i] && die_q[i] == m_die && bank_q[i] == m_bank) m_hit = 1'b1;
      if (!vld_q[i]) begin
        free_any = 1'b1;
        free_idx = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en && free_any) vld_q[free_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && free_any) begin
      die_q[free_idx]  <= m_die;
      bank_q[free_idx] <= m_bank;
    end
  end
endmodule

// File: rtl/spr_mgmt_ctrl.sv
module spr_mgmt_ctrl
  import spr_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int THRESH  = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             row_hit,
  input  logic             bank_hit,
  input  logic [CNT_W-1:0] bank_cnt,
  input  logic             coarse_free,
  output logic             row_wr,
  output logic [IDX_W-1:0] row_idx,
  output logic             row_inv,
  output logic             bank_wr,
  output logic             ack,
  output logic [1:0]       result,
  output logic             exhausted
);
  logic [CNT_W-1:0] ptr_q;
  logic             ptr_full;
  ins_res_e         res_d;
  ins_res_e         res_q;
  logic             ack_q;
  logic             exh_q;

  assign ptr_full = (ptr_q == CNT_W'(ENTRIES));
  assign row_idx  = ptr_q[IDX_W-1:0];

  always_comb begin
    res_d   = INS_REFUSED;
    row_wr  = 1'b0;
    row_inv = 1'b0;
    bank_wr = 1'b0;
    if (bank_hit || row_hit) begin
      res_d = INS_COVERED;
    end else if (bank_cnt >= CNT_W'(THRESH) && coarse_free) begin
      res_d   = INS_PROMOTE;
      row_inv = req;
      bank_wr = req;
    end else if (!ptr_full) begin
      res_d  = INS_ROW;
      row_wr = req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ack_q <= 1'b0;
      res_q <= INS_ROW;
      exh_q <= 1'b0;
    end else begin
      ack_q <= req;
      if (req) res_q <= res_d;
      if (row_wr) ptr_q <= ptr_q + CNT_W'(1);
      if (req && res_d == INS_REFUSED) exh_q <= 1'b1;
    end
  end

  assign ack       = ack_q;
  assign result    = res_q;
  assign exhausted = exh_q;
endmodule

// File: rtl/spr_pipe_reg.sv
module spr_pipe_reg #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);
  logic          vld_q;
  logic [PW-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= 1'b0;
    else if (in_ready) vld_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) dat_q <= in_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
endmodule

// File: rtl/spr_redirector.sv
module spr_redirector
  import spr_pkg::*;
#(
  parameter int DIE_W        = 3,
  parameter int BANK_W       = 3,
  parameter int ROW_W        = 16,
  parameter int FINE_ROWS    = 16,
  parameter int COARSE_BANKS = 2,
  parameter int THRESH       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [DIE_W-1:0]  lk_die,
  input  logic [BANK_W-1:0] lk_bank,
  input  logic [ROW_W-1:0]  lk_row,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [1:0]        rs_region,
  output logic [DIE_W-1:0]  rs_die,
  output logic [BANK_W-1:0] rs_bank,
  output logic [ROW_W-1:0]  rs_row,
  input  logic              mg_req,
  input  logic [DIE_W-1:0]  mg_die,
  input  logic [BANK_W-1:0] mg_bank,
  input  logic [ROW_W-1:0]  mg_row,
  output logic              mg_ack,
  output logic [1:0]        mg_result,
  output logic              exhausted
);
  localparam int IDX_W  = (FINE_ROWS > 1) ? $clog2(FINE_ROWS) : 1;
  localparam int CNT_W  = $clog2(FINE_ROWS + 1);
  localparam int SLOT_W = (COARSE_BANKS > 1) ? $clog2(COARSE_BANKS) : 1;
  localparam int PW     = 2 + DIE_W + BANK_W + ROW_W;

  logic              rt_hit;
  logic [IDX_W-1:0]  rt_spare;
  logic              rt_mrow_hit;
  logic [CNT_W-1:0]  rt_mcnt;
  logic              bt_hit;
  logic [SLOT_W-1:0] bt_idx;
  logic              bt_mhit;
  logic              bt_free;
  logic              c_row_wr;
  logic [IDX_W-1:0]  c_row_idx;
  logic              c_row_inv;
  logic              c_bank_wr;

  region_e           x_region;
  logic [DIE_W-1:0]  x_die;
  logic [BANK_W-1:0] x_bank;
  logic [ROW_W-1:0]  x_row;
  logic [PW-1:0]     pipe_out;

  spr_row_table #(
    .DIE_W(DIE_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .ENTRIES(FINE_ROWS)
  ) row_tbl_i (
    .clk(clk), .rst_n(rst_n),
    .q_die(lk_die), .q_bank(lk_bank), .q_row(lk_row),
    .q_hit(rt_hit), .q_spare(rt_spare),
    .m_die(mg_die), .m_bank(mg_bank), .m_row(mg_row),
    .m_row_hit(rt_mrow_hit), .m_bank_cnt(rt_mcnt),
    .wr_en(c_row_wr), .wr_idx(c_row_idx), .inv_en(c_row_inv)
  );

  spr_bank_table #(
    .DIE_W(DIE_W), .BANK_W(BANK_W), .SLOTS(COARSE_BANKS)
  ) bank_tbl_i (
    .clk(clk), .rst_n(rst_n),
    .q_die(lk_die), .q_bank(lk_bank),
    .q_hit(bt_hit), .q_idx(bt_idx),
    .m_die(mg_die), .m_bank(mg_bank),
    .m_hit(bt_mhit), .free_any(bt_free),
    .wr_en(c_bank_wr)
  );

  spr_mgmt_ctrl #(
    .ENTRIES(FINE_ROWS), .THRESH(THRESH)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .req(mg_req),
    .row_hit(rt_mrow_hit), .bank_hit(bt_mhit), .bank_cnt(rt_mcnt),
    .coarse_free(bt_free),
    .row_wr(c_row_wr), .row_idx(c_row_idx), .row_inv(c_row_inv),
    .bank_wr(c_bank_wr),
    .ack(mg_ack), .result(mg_result), .exhausted(exhausted)
  );

  // Bank table first; fine table only when the bank is not replaced.
  always_comb begin
    x_region = REG_ORIG;
    x_die    = lk_die;
    x_bank   = lk_bank;
    x_row    = lk_row;
    if (bt_hit) begin
      x_region = REG_COARSE;
      x_die    = '0;
      x_bank   = BANK_W'(bt_idx);
    end else if (rt_hit) begin
      x_region = REG_FINE;
      x_die    = '0;
      x_bank   = BANK_W'(COARSE_BANKS);
      x_row    = ROW_W'(rt_spare);
    end
  end

  spr_pipe_reg #(.PW(PW)) out_reg_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(lk_valid), .in_ready(lk_ready),
    .in_data({x_region, x_die, x_bank, x_row}),
    .out_valid(rs_valid), .out_ready(rs_ready),
    .out_data(pipe_out)
  );

  assign {rs_region, rs_die, rs_bank, rs_row} = pipe_out;
endmodule

// File: rtl/spr_redirector_chk.sv
module spr_redirector_chk #(
  parameter int DIE_W  = 3,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [DIE_W-1:0]  lk_die,
  input logic [BANK_W-1:0] lk_bank,
  input logic [ROW_W-1:0]  lk_row,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic [1:0]        rs_region,
  input logic [DIE_W-1:0]  rs_die,
  input logic [BANK_W-1:0] rs_bank,
  input logic [ROW_W-1:0]  rs_row,
  input logic              mg_req,
  input logic              mg_ack,
  input logic [1:0]        mg_result,
  input logic              exhausted
);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_region) && $stable(rs_die)
                                 && $stable(rs_bank) && $stable(rs_row)));
  // R2
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |-> !lk_ready);
  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rs_valid);
  // R3
  orig_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (rs_region != 2'd0 ||
      (rs_die == $past(lk_die) && rs_bank == $past(lk_bank) && rs_row == $past(lk_row))));
  // R6
  coarse_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (rs_region != 2'd2 || rs_row == $past(lk_row)));
  // R4
  spare_die_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_region != 2'd0) |-> rs_die == '0);
  // R7
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mg_req |=> mg_ack);
  // R7
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mg_req |=> !mg_ack);
  // R11
  exhaust_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |=> exhausted);
  // R11
  refuse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_ack && mg_result == 2'd3) |-> exhausted);
endmodule

bind spr_redirector spr_redirector_chk #(
  .DIE_W(DIE_W), .BANK_W(BANK_W), .ROW_W(ROW_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_die(lk_die), .lk_bank(lk_bank), .lk_row(lk_row),
  .rs_valid(rs_valid), .rs_ready(rs_ready),
  .rs_region(rs_region), .rs_die(rs_die), .rs_bank(rs_bank), .rs_row(rs_row),
  .mg_req(mg_req), .mg_ack(mg_ack), .mg_result(mg_result),
  .exhausted(exhausted)
);

// File: tb/spr_redirector_tb.sv
`timescale 1ns/1ps
module spr_redirector_tb_top;
  localparam int FINE = 16;
  localparam int NCB  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [2:0]  lk_die = '0;
  logic [2:0]  lk_bank = '0;
  logic [15:0] lk_row = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic [1:0]  rs_region;
  logic [2:0]  rs_die;
  logic [2:0]  rs_bank;
  logic [15:0] rs_row;
  logic        mg_req = 1'b0;
  logic [2:0]  mg_die = '0;
  logic [2:0]  mg_bank = '0;
  logic [15:0] mg_row = '0;
  logic        mg_ack;
  logic [1:0]  mg_result;
  logic        exhausted;

  int checks = 0;
  int failures = 0;

  // reference state
  bit m_rv[FINE];
  int m_rd[FINE], m_rb[FINE], m_rr[FINE];
  bit m_bv[NCB];
  int m_bd[NCB], m_bb[NCB];
  int m_ptr;
  bit m_exh;

  always #2 clk = ~clk;

  spr_redirector dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_die(lk_die), .lk_bank(lk_bank), .lk_row(lk_row),
    .rs_valid(rs_valid), .rs_ready(rs_ready),
    .rs_region(rs_region), .rs_die(rs_die), .rs_bank(rs_bank), .rs_row(rs_row),
    .mg_req(mg_req), .mg_die(mg_die), .mg_bank(mg_bank), .mg_row(mg_row),
    .mg_ack(mg_ack), .mg_result(mg_result), .exhausted(exhausted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int m_install(int d, int b, int r);
    int cnt = 0;
    int fr = -1;
    for (int i = 0; i < NCB; i++)
      if (m_bv[i] && m_bd[i] == d && m_bb[i] == b) return 2;
    for (int i = 0; i < FINE; i++)
      if (m_rv[i] && m_rd[i] == d && m_rb[i] == b) begin
        cnt++;
        if (m_rr[i] == r) return 2;
      end
    for (int i = NCB - 1; i >= 0; i--) if (!m_bv[i]) fr = i;
    if (cnt >= 4 && fr >= 0) begin
      m_bv[fr] = 1; m_bd[fr] = d; m_bb[fr] = b;
      for (int i = 0; i < FINE; i++)
        if (m_rd[i] == d && m_rb[i] == b) m_rv[i] = 0;
      return 1;
    end
    if (m_ptr < FINE) begin
      m_rv[m_ptr] = 1; m_rd[m_ptr] = d; m_rb[m_ptr] = b; m_rr[m_ptr] = r;
      m_ptr++;
      return 0;
    end
    m_exh = 1;
    return 3;
  endfunction

  function automatic void m_lookup(int d, int b, int r,
                                   output int eg, output int ed, output int eb, output int er);
    eg = 0; ed = d; eb = b; er = r;
    for (int i = 0; i < FINE; i++)
      if (m_rv[i] && m_rd[i] == d && m_rb[i] == b && m_rr[i] == r) begin
        eg = 1; ed = 0; eb = NCB; er = i;
      end
    for (int i = 0; i < NCB; i++)
      if (m_bv[i] && m_bd[i] == d && m_bb[i] == b) begin
        eg = 2; ed = 0; eb = i; er = r;
      end
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; lk_valid = 1'b0; mg_req = 1'b0; rs_ready = 1'b1;
    for (int i = 0; i < FINE; i++) begin m_rv[i] = 0; m_rd[i] = -1; m_rb[i] = -1; m_rr[i] = -1; end
    for (int i = 0; i < NCB; i++) begin m_bv[i] = 0; m_bd[i] = -1; m_bb[i] = -1; end
    m_ptr = 0; m_exh = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(rs_valid == 1'b0, "R1 rs_valid", int'(rs_valid), 0);
    chk(mg_ack == 1'b0, "R1 mg_ack", int'(mg_ack), 0);
    chk(exhausted == 1'b0, "R1 exhausted", int'(exhausted), 0);
    chk(lk_ready == 1'b1, "R1 lk_ready", int'(lk_ready), 1);
  endtask

  task automatic lookup(input int d, input int b, input int r, input string tag);
    int eg, ed, eb, er;
    @(negedge clk);
    lk_valid = 1'b1; lk_die = 3'(d); lk_bank = 3'(b); lk_row = 16'(r); rs_ready = 1'b1;
    m_lookup(d, b, r, eg, ed, eb, er);
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid == 1'b1, {tag, " valid"}, int'(rs_valid), 1);
    chk(int'(rs_region) == eg, {tag, " region"}, int'(rs_region), eg);
    chk(int'(rs_die) == ed, {tag, " die"}, int'(rs_die), ed);
    chk(int'(rs_bank) == eb, {tag, " bank"}, int'(rs_bank), eb);
    chk(int'(rs_row) == er, {tag, " row"}, int'(rs_row), er);
  endtask

  task automatic install(input int d, input int b, input int r, input string tag);
    int exp;
    @(negedge clk);
    mg_req = 1'b1; mg_die = 3'(d); mg_bank = 3'(b); mg_row = 16'(r);
    exp = m_install(d, b, r);
    @(negedge clk);
    mg_req = 1'b0;
    chk(mg_ack == 1'b1, {tag, " ack"}, int'(mg_ack), 1);
    chk(int'(mg_result) == exp, {tag, " result"}, int'(mg_result), exp);
    chk(exhausted == m_exh, {tag, " exhausted"}, int'(exhausted), int'(m_exh));
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    lookup(1, 2, 100, "R3 unmapped");
    install(1, 2, 100, "R7 first row");
    lookup(1, 2, 100, "R4 fine hit");
    lookup(1, 2, 101, "R3 neighbour");
    install(1, 2, 100, "R8 same row");
    for (int k = 101; k <= 103; k++) install(1, 2, k, "R5 in-order");
    lookup(1, 2, 103, "R5 spare row 3");
    install(1, 2, 104, "R9 promote");
    lookup(1, 2, 100, "R6 priority");
    lookup(1, 2, 5000, "R6 coarse row kept");
    install(1, 2, 7, "R8 bank covered");

    // R2 back-pressure
    @(negedge clk);
    rs_ready = 1'b0; lk_valid = 1'b1; lk_die = 3'd1; lk_bank = 3'd2; lk_row = 16'd42;
    @(negedge clk);
    chk(rs_valid && rs_region == 2'd2 && rs_row == 16'd42, "R2 first held", int'(rs_row), 42);
    chk(lk_ready == 1'b0, "R2 stall ready", int'(lk_ready), 0);
    lk_die = 3'd4; lk_bank = 3'd4; lk_row = 16'd9;
    @(negedge clk);
    chk(rs_valid && rs_region == 2'd2 && rs_row == 16'd42, "R2 still held", int'(rs_row), 42);
    rs_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rs_valid && rs_region == 2'd0 && rs_row == 16'd9 && rs_die == 3'd4, "R2 next taken",
        int'(rs_row), 9);

    for (int k = 10; k <= 14; k++) install(3, 5, k, "R9 second promote");
    lookup(3, 5, 11, "R6 coarse index 1");
    lookup(1, 2, 101, "R5 freed rows unused");
    for (int k = 0; k <= 4; k++) install(0, 0, k, "R10 fallback");
    lookup(0, 0, 4, "R10 fine after threshold");
    for (int k = 0; k <= 2; k++) install(0, 1, k, "R5 fill");
    install(0, 1, 3, "R11 refuse");
    lookup(0, 1, 3, "R11 unchanged miss");
    lookup(0, 1, 2, "R11 unchanged hit");
    install(0, 1, 2, "R8 covered after exhaust");
    install(6, 6, 6, "R11 sticky");

    // constrained random against the reference
    do_reset();
    void'($urandom(32'd1234));
    for (int n = 0; n < 600; n++) begin
      int d = $urandom_range(0, 1);
      int b = $urandom_range(0, 1);
      int r = $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) install(d, b, r, "R7 random install");
      else lookup(d, b, r, "R4 random lookup");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule